// File: doc/BRIEF.md
# Parallel MAC Matrix Multiplier

This block multiplies two signed integer matrices, C = A × B, on a fixed square grid of DIM × DIM multiply-accumulate cells. The active sizes are given at run time: a row and column count for A and for B, each from zero up to DIM. Both operand matrices are first written element by element into two local banks. The A bank presents a whole column of A in one cycle, and the B bank presents a whole row of B in one cycle.

A start pulse latches the four counts. The block then runs one step per cycle for k = 0 up to (A column count − 1). In each step, every cell (i,j) adds A[i][k]·B[k][j] to its own accumulator. An operand that lies outside the programmed sizes is replaced by zero. The first step loads the product into the accumulator rather than adding it, so results left from an earlier run never leak into the new one.

A one-cycle done flag marks completion. The result matrix then stays unchanged until the next accepted start. It is read one element at a time through an index-addressed port that has one cycle of latency.

Top module: `mac_grid_mult`

## Requirements
- R1: While reset is low, and in the first cycle after it, busy and done are 0, rd_data is 0, and every element of C and of both operand banks reads as zero.
- R2: After done, C[i][j] equals the sum over k < Ka of a(i,k)·b(k,j), keeping the low DW bits of every product and of every sum (two's-complement wrap). A count above DIM is latched as DIM.
- R3: a(i,k) is A[i][k] when i < A row count and k < A column count, and 0 otherwise.
- R4: b(k,j) is B[k][j] when k < B row count and j < B column count, and 0 otherwise, even when the B row count differs from the A column count.
- R5: The first step of a run replaces each accumulator with its product, so no value from an earlier run survives.
- R6: When start is sampled at edge e in the idle state with Ka = min(A column count, DIM), busy is high after edges e … e+Ka−1, and done is high for exactly one cycle, after edge e+Ka.
- R7: A start pulse while busy is ignored. The counts latched at the accepted start stay in force until that run ends.
- R8: A start with A column count 0 runs no step, raises done after the start edge, and leaves C unchanged.
- R9: rd_data shows C[rd_row][rd_col] one cycle after the index is applied, and 0 when either index is DIM or more.
- R10: C does not change outside a running step. Operand writes while idle change only the banks.
- R11: Operand writes (a_wr_en, b_wr_en) that arrive while busy are dropped, and later runs see the old bank contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_wr_en | input | 1 | Write one element of A |
| a_wr_row | input | IW | Row index of the A write |
| a_wr_col | input | IW | Column index of the A write |
| a_wr_data | input | DW | Signed A element |
| b_wr_en | input | 1 | Write one element of B |
| b_wr_row | input | IW | Row index of the B write |
| b_wr_col | input | IW | Column index of the B write |
| b_wr_data | input | DW | Signed B element |
| start | input | 1 | Start pulse, sampled when idle |
| a_rows | input | CW | A row count |
| a_cols | input | CW | A column count (number of steps) |
| b_rows | input | CW | B row count |
| b_cols | input | CW | B column count |
| busy | output | 1 | Steps in progress |
| done | output | 1 | One-cycle completion flag |
| rd_row | input | CW | Result row index |
| rd_col | input | CW | Result column index |
| rd_data | output | DW | Selected result element, one cycle later |

## Verification
The bench builds the block with its defaults, DIM = 4 and DW = 32. With these values IW is 2 and CW is 3, so every count from 0 to 7 can be driven. That covers counts above DIM, which must be clamped, and read indices 4 to 7, which must return zero. The 32-bit width lets full-scale operands show the wrap of products and sums. A 4 × 4 grid is small enough that mismatched inner sizes, single-row and single-column shapes, zero-step runs and a large number of random sizes all finish quickly.

// File: rtl/mgm_pkg.sv
// Shared types for the parallel MAC matrix multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package mgm_pkg;

    // Sequencer state: idle, or stepping through k
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/mgm_operand_bank.sv
// One DIM x DIM operand bank, written one element at a time, that returns a
// whole slice per cycle. SLICE_COL = 1 returns column sel (mem[x][sel]);
// SLICE_COL = 0 returns row sel (mem[sel][x]).
// Assumes: writes with an index of DIM or more are discarded; sel < DIM.
module mgm_operand_bank #(
    parameter int DIM       = 4,
    parameter int DW        = 32,
    parameter int IW        = 2,
    parameter bit SLICE_COL = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IW-1:0]           wr_row,
    input  logic [IW-1:0]           wr_col,
    input  logic [DW-1:0]           wr_data,
    input  logic [IW-1:0]           sel,
    output logic [DIM-1:0][DW-1:0]  slice
);

    logic [DW-1:0] mem [DIM][DIM];

    // Element storage: cleared by reset, written with range-guarded indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DIM; r++) begin
                for (int c = 0; c < DIM; c++) begin
                    mem[r][c] <= '0;
                end
            end
        end else if (wr_en && (int'(wr_row) < DIM) && (int'(wr_col) < DIM)) begin
            mem[wr_row][wr_col] <= wr_data;
        end
    end

    // Slice read: the orientation is chosen at elaboration
    generate
        if (SLICE_COL) begin : g_col_slice
            for (genvar x = 0; x < DIM; x++) begin : g_x
                assign slice[x] = mem[x][sel];
            end
        end else begin : g_row_slice
            for (genvar x = 0; x < DIM; x++) begin : g_x
                assign slice[x] = mem[sel][x];
            end
        end
    endgenerate

endmodule

// File: rtl/mgm_mac_cell.sv
// One multiply-accumulate cell. On a step it stores (first ? 0 : acc) + a*b,
// keeping the low DW bits.
// Assumes: a and b have already been masked by the caller.
module mgm_mac_cell #(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic                 first,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [DW-1:0] acc
);

    logic signed [DW-1:0] prod;
    logic signed [DW-1:0] base;

    // Truncated product and the value it is added to
    always_comb begin
        prod = a * b;
        base = first ? '0 : acc;
    end

    // Accumulator register: updated only on a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (step_en) begin
            acc <= base + prod;
        end
    end

endmodule

// File: rtl/mgm_seq_ctrl.sv
// Step sequencer. Latches the clamped counts on an idle start, then steps
// k from 0 to Ka-1, one step per cycle, and flags done for one cycle.
// Assumes: start is a level sampled each cycle; it is ignored while running.
module mgm_seq_ctrl
    import mgm_pkg::*;
#(
    parameter int DIM = 4,
    parameter int IW  = 2,
    parameter int CW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] a_rows,
    input  logic [CW-1:0] a_cols,
    input  logic [CW-1:0] b_rows,
    input  logic [CW-1:0] b_cols,
    output logic          busy,
    output logic          done,
    output logic          step_en,
    output logic          first,
    output logic [IW-1:0] k_q,
    output logic [CW-1:0] ar_q,
    output logic [CW-1:0] ac_q,
    output logic [CW-1:0] br_q,
    output logic [CW-1:0] bc_q
);

    localparam logic [CW-1:0] DIM_C = CW'(DIM);

    seq_state_t    state;
    logic [CW-1:0] ar_c, ac_c, br_c, bc_c;
    logic          last_step;

    // Clamp incoming counts to the physical grid size
    always_comb begin
        ar_c = (a_rows > DIM_C) ? DIM_C : a_rows;
        ac_c = (a_cols > DIM_C) ? DIM_C : a_cols;
        br_c = (b_rows > DIM_C) ? DIM_C : b_rows;
        bc_c = (b_cols > DIM_C) ? DIM_C : b_cols;
    end

    // Decode of the final step
    assign last_step = (int'(k_q) == int'(ac_q) - 1);

    // State, step counter, latched counts and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            k_q   <= '0;
            ar_q  <= '0;
            ac_q  <= '0;
            br_q  <= '0;
            bc_q  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ar_q <= ar_c;
                        ac_q <= ac_c;
                        br_q <= br_c;
                        bc_q <= bc_c;
                        k_q  <= '0;
                        if (ac_c == '0) begin
                            done <= 1'b1;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (last_step) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        k_q   <= '0;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status decode towards the grid
    always_comb begin
        busy    = (state == ST_RUN);
        step_en = (state == ST_RUN);
        first   = (k_q == '0);
    end

endmodule

// File: rtl/mac_grid_mult.sv
// Parallel MAC matrix multiplier top. Holds the A bank (column slices) and
// the B bank (row slices), masks the operands to the latched sizes, drives a
// DIM x DIM grid of MAC cells and provides a registered result read port.
// Assumes: synchronous active-low reset; operand writes only take effect
// while idle.
module mac_grid_mult #(
    parameter  int DIM = 4,
    parameter  int DW  = 32,
    localparam int IW  = (DIM > 1) ? $clog2(DIM) : 1,
    localparam int CW  = $clog2(DIM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_wr_en,
    input  logic [IW-1:0] a_wr_row,
    input  logic [IW-1:0] a_wr_col,
    input  logic [DW-1:0] a_wr_data,
    input  logic          b_wr_en,
    input  logic [IW-1:0] b_wr_row,
    input  logic [IW-1:0] b_wr_col,
    input  logic [DW-1:0] b_wr_data,
    input  logic          start,
    input  logic [CW-1:0] a_rows,
    input  logic [CW-1:0] a_cols,
    input  logic [CW-1:0] b_rows,
    input  logic [CW-1:0] b_cols,
    output logic          busy,
    output logic          done,
    input  logic [CW-1:0] rd_row,
    input  logic [CW-1:0] rd_col,
    output logic [DW-1:0] rd_data
);

    logic                   step_en, first;
    logic [IW-1:0]          k_q;
    logic [CW-1:0]          ar_q, ac_q, br_q, bc_q;
    logic [DIM-1:0][DW-1:0] a_slice, b_slice;
    logic [DIM-1:0][DW-1:0] a_op, b_op;
    logic [DW-1:0]          c_mat [DIM][DIM];
    logic [DIM*DIM*DW-1:0]  c_flat;

    mgm_seq_ctrl #(.DIM(DIM), .IW(IW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_rows(a_rows), .a_cols(a_cols), .b_rows(b_rows), .b_cols(b_cols),
        .busy(busy), .done(done), .step_en(step_en), .first(first),
        .k_q(k_q), .ar_q(ar_q), .ac_q(ac_q), .br_q(br_q), .bc_q(bc_q)
    );

    mgm_operand_bank #(.DIM(DIM), .DW(DW), .IW(IW), .SLICE_COL(1'b1)) u_bank_a (
        .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en && !busy),
        .wr_row(a_wr_row), .wr_col(a_wr_col), .wr_data(a_wr_data),
        .sel(k_q), .slice(a_slice)
    );

    mgm_operand_bank #(.DIM(DIM), .DW(DW), .IW(IW), .SLICE_COL(1'b0)) u_bank_b (
        .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en && !busy),
        .wr_row(b_wr_row), .wr_col(b_wr_col), .wr_data(b_wr_data),
        .sel(k_q), .slice(b_slice)
    );

    // Operand masking against the latched sizes, one lane per row or column
    generate
        for (genvar i = 0; i < DIM; i++) begin : g_amask
            assign a_op[i] = ((i < int'(ar_q)) && (int'(k_q) < int'(ac_q))) ? a_slice[i] : '0;
        end
        for (genvar j = 0; j < DIM; j++) begin : g_bmask
            assign b_op[j] = ((int'(k_q) < int'(br_q)) && (j < int'(bc_q))) ? b_slice[j] : '0;
        end
    endgenerate

    // The cell grid: cell (i,j) takes lane i of A and lane j of B
    generate
        for (genvar i = 0; i < DIM; i++) begin : g_row
            for (genvar j = 0; j < DIM; j++) begin : g_col
                mgm_mac_cell #(.DW(DW)) u_cell (
                    .clk(clk), .rst_n(rst_n), .step_en(step_en), .first(first),
                    .a(a_op[i]), .b(b_op[j]), .acc(c_mat[i][j])
                );
                assign c_flat[(i*DIM+j)*DW +: DW] = c_mat[i][j];
            end
        end
    endgenerate

    // Registered result read; out-of-range indices return zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if ((int'(rd_row) < DIM) && (int'(rd_col) < DIM)) begin
            rd_data <= c_mat[rd_row[IW-1:0]][rd_col[IW-1:0]];
        end else begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/mgm_checker.sv
// Protocol and hold checks for mac_grid_mult, attached with bind.
// Assumes: the internal signals named below exist in the top module.
module mgm_checker #(
    parameter  int DIM = 4,
    parameter  int DW  = 32,
    localparam int IW  = (DIM > 1) ? $clog2(DIM) : 1,
    localparam int CW  = $clog2(DIM + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic [CW-1:0]         a_cols,
    input logic                  busy,
    input logic                  done,
    input logic                  step_en,
    input logic [IW-1:0]         k_q,
    input logic [CW-1:0]         ac_q,
    input logic [CW-1:0]         rd_row,
    input logic [CW-1:0]         rd_col,
    input logic [DW-1:0]         rd_data,
    input logic [DIM*DIM*DW-1:0] c_flat
);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(k_q) < int'(ac_q)));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ac_q));

    p_zero_cols_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (a_cols == '0)) |=> (done && !busy));

    p_rd_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(rd_row) >= DIM) || (int'(rd_col) >= DIM)) |=> (rd_data == '0));

    p_c_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(c_flat));

endmodule

bind mac_grid_mult mgm_checker #(.DIM(DIM), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .a_cols(a_cols),
    .busy(busy), .done(done), .step_en(step_en), .k_q(k_q), .ac_q(ac_q),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data), .c_flat(c_flat)
);

// File: tb/mac_grid_mult_bench.sv
`timescale 1ns/1ps
module mac_grid_mult_bench;

    localparam int DIM = 4;
    localparam int DW  = 32;
    localparam int IW  = (DIM > 1) ? $clog2(DIM) : 1;
    localparam int CW  = $clog2(DIM + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_wr_en = 1'b0, b_wr_en = 1'b0;
    logic [IW-1:0] a_wr_row = '0, a_wr_col = '0, b_wr_row = '0, b_wr_col = '0;
    logic [DW-1:0] a_wr_data = '0, b_wr_data = '0;
    logic          start = 1'b0;
    logic [CW-1:0] a_rows = '0, a_cols = '0, b_rows = '0, b_cols = '0;
    logic          busy, done;
    logic [CW-1:0] rd_row = '0, rd_col = '0;
    logic [DW-1:0] rd_data;

    mac_grid_mult #(.DIM(DIM), .DW(DW)) u_mac_grid_mult (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_wr_row(a_wr_row), .a_wr_col(a_wr_col), .a_wr_data(a_wr_data),
        .b_wr_en(b_wr_en), .b_wr_row(b_wr_row), .b_wr_col(b_wr_col), .b_wr_data(b_wr_data),
        .start(start), .a_rows(a_rows), .a_cols(a_cols), .b_rows(b_rows), .b_cols(b_cols),
        .busy(busy), .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int    vectors = 0;
    int    fails = 0;
    bit    mon_on = 1'b0;
    string phase = "R1";

    // Cycle model state
    int mA [DIM][DIM];
    int mB [DIM][DIM];
    int mC [DIM][DIM];
    int mbusy, mdone, mk, mar, mac, mbr, mbc, mrd;

    // Software reference state (updated by the test sequence only)
    int sA [DIM][DIM];
    int sB [DIM][DIM];
    int sC [DIM][DIM];

    function automatic int clampc(int v);
        return (v > DIM) ? DIM : v;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle model: advances on every rising edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DIM; i++)
                for (int j = 0; j < DIM; j++) begin
                    mA[i][j] = 0; mB[i][j] = 0; mC[i][j] = 0;
                end
            mbusy = 0; mdone = 0; mk = 0; mrd = 0;
            mar = 0; mac = 0; mbr = 0; mbc = 0;
        end else begin
            int nd;
            nd = 0;
            if (int'(rd_row) < DIM && int'(rd_col) < DIM) mrd = mC[rd_row][rd_col];
            else mrd = 0;
            if (!mbusy) begin
                if (a_wr_en && int'(a_wr_row) < DIM && int'(a_wr_col) < DIM)
                    mA[a_wr_row][a_wr_col] = int'(a_wr_data);
                if (b_wr_en && int'(b_wr_row) < DIM && int'(b_wr_col) < DIM)
                    mB[b_wr_row][b_wr_col] = int'(b_wr_data);
            end
            if (mbusy) begin
                for (int i = 0; i < DIM; i++)
                    for (int j = 0; j < DIM; j++) begin
                        int av, bv;
                        av = (i < mar && mk < mac) ? mA[i][mk] : 0;
                        bv = (mk < mbr && j < mbc) ? mB[mk][j] : 0;
                        mC[i][j] = ((mk == 0) ? 0 : mC[i][j]) + av * bv;
                    end
                mk++;
                if (mk == mac) begin mbusy = 0; nd = 1; end
            end else if (start) begin
                mar = clampc(int'(a_rows)); mac = clampc(int'(a_cols));
                mbr = clampc(int'(b_rows)); mbc = clampc(int'(b_cols));
                mk = 0;
                if (mac == 0) nd = 1; else mbusy = 1;
            end
            mdone = nd;
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            check("R6 busy", longint'(busy), longint'(mbusy));
            check("R6 done", longint'(done), longint'(mdone));
            check({phase, " rd_data"}, longint'($signed(rd_data)), longint'(mrd));
        end
    end

    task automatic write_a(int r, int c, int v, bit track);
        a_wr_en = 1'b1; a_wr_row = IW'(r); a_wr_col = IW'(c); a_wr_data = DW'(v);
        if (track) sA[r][c] = v;
        @(negedge clk);
        a_wr_en = 1'b0;
    endtask

    task automatic write_b(int r, int c, int v, bit track);
        b_wr_en = 1'b1; b_wr_row = IW'(r); b_wr_col = IW'(c); b_wr_data = DW'(v);
        if (track) sB[r][c] = v;
        @(negedge clk);
        b_wr_en = 1'b0;
    endtask

    task automatic load_random(int span);
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin
                write_a(r, c, $signed($urandom_range(2*span, 0)) - span, 1'b1);
                write_b(r, c, $signed($urandom_range(2*span, 0)) - span, 1'b1);
            end
    endtask

    // Reference: a plain triple loop over the bench's own operand copies
    task automatic ref_update(int ar, int ac, int br, int bc);
        ar = clampc(ar); ac = clampc(ac); br = clampc(br); bc = clampc(bc);
        if (ac == 0) return;
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                int s;
                s = 0;
                for (int k = 0; k < ac; k++) begin
                    int av, bv;
                    av = (i < ar) ? sA[i][k] : 0;
                    bv = (k < br && j < bc) ? sB[k][j] : 0;
                    s = s + av * bv;
                end
                sC[i][j] = s;
            end
    endtask

    task automatic run_mult(string tag, int ar, int ac, int br, int bc, bit poke);
        int n;
        start = 1'b1;
        a_rows = CW'(ar); a_cols = CW'(ac); b_rows = CW'(br); b_cols = CW'(bc);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            if (poke && n == 1) begin
                start = 1'b1; a_rows = CW'(1); a_cols = CW'(1); b_cols = CW'(1);
            end
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        check({tag, " R6 steps to done"}, n, clampc(ac));
        ref_update(ar, ac, br, bc);
        @(negedge clk);
        check({tag, " R6 done one cycle"}, longint'(done), 0);
    endtask

    task automatic read_all(string tag);
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin
                rd_row = CW'(r); rd_col = CW'(c);
                @(negedge clk);
                check(tag, longint'($signed(rd_data)), longint'(sC[r][c]));
            end
    endtask

    // Watchdog: a hung run still reaches the summary line
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                sA[i][j] = 0; sB[i][j] = 0; sC[i][j] = 0;
            end
        repeat (4) @(negedge clk);
        // R1: outputs while reset is held
        check("R1 busy in reset", longint'(busy), 0);
        check("R1 done in reset", longint'(done), 0);
        check("R1 rd_data in reset", longint'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        phase = "R1";
        check("R1 busy after reset", longint'(busy), 0);
        read_all("R1 C cleared");
        run_mult("R1 banks cleared", 4, 4, 4, 4, 1'b0);
        read_all("R1 zero banks give zero C");

        // R2: full square product
        phase = "R2";
        load_random(1000);
        run_mult("R2 square", 4, 4, 4, 4, 1'b0);
        read_all("R2 square");

        // R2: counts above DIM are clamped
        run_mult("R2 clamp", 7, 6, 5, 7, 1'b0);
        read_all("R2 clamp");

        // R2: wrap of products and sums
        for (int r = 0; r < DIM; r++)
            for (int c = 0; c < DIM; c++) begin
                write_a(r, c, 32'h7fffffff - r, 1'b1);
                write_b(r, c, -32'sd2147483647 + c, 1'b1);
            end
        run_mult("R2 wrap", 4, 4, 4, 4, 1'b0);
        read_all("R2 wrap");

        // R3: A row count masks rows; R4: B row count below A column count
        phase = "R3";
        load_random(50);
        run_mult("R3 rows", 2, 4, 4, 4, 1'b0);
        read_all("R3 A rows masked");
        phase = "R4";
        run_mult("R4 inner mismatch", 4, 4, 2, 3, 1'b0);
        read_all("R4 B rows and cols masked");
        run_mult("R4 non-square", 3, 2, 4, 1, 1'b0);
        read_all("R4 non-square");

        // R5: a short run after a full one leaves no stale sums
        phase = "R5";
        run_mult("R5 full", 4, 4, 4, 4, 1'b0);
        run_mult("R5 one step", 4, 1, 4, 4, 1'b0);
        read_all("R5 first step overwrites");

        // R7: a start pulse while busy is ignored
        phase = "R7";
        run_mult("R7 poke", 4, 4, 4, 4, 1'b1);
        read_all("R7 start ignored while busy");

        // R8: zero A columns leaves C alone
        phase = "R8";
        run_mult("R8 zero cols", 4, 0, 4, 4, 1'b0);
        read_all("R8 C unchanged");

        // R9: out-of-range read indices give zero
        phase = "R9";
        for (int r = 0; r < 8; r++) begin
            rd_row = CW'(r); rd_col = CW'(7 - r);
            @(negedge clk);
            check("R9 read", longint'($signed(rd_data)),
                  (r < DIM && 7 - r < DIM) ? longint'(sC[r][7-r]) : 0);
        end

        // R10: idle bank writes do not touch C
        phase = "R10";
        for (int r = 0; r < DIM; r++) write_a(r, r, 12345 + r, 1'b1);
        repeat (3) @(negedge clk);
        read_all("R10 C held while idle");

        // R11: writes during a run are dropped
        phase = "R11";
        start = 1'b1;
        a_rows = CW'(4); a_cols = CW'(4); b_rows = CW'(4); b_cols = CW'(4);
        @(negedge clk);
        start = 1'b0;
        write_a(0, 0, 777777, 1'b0);
        write_b(1, 1, -555, 1'b0);
        while (!done) @(negedge clk);
        ref_update(4, 4, 4, 4);
        @(negedge clk);
        read_all("R11 writes in run dropped");
        run_mult("R11 rerun", 4, 4, 4, 4, 1'b0);
        read_all("R11 banks kept old data");

        // Random sizes, including zero counts
        phase = "R2";
        for (int t = 0; t < 24; t++) begin
            load_random(3000);
            run_mult("R2 random", $urandom_range(DIM, 0), $urandom_range(DIM, 0),
                     $urandom_range(DIM, 0), $urandom_range(DIM, 0), 1'b0);
            read_all("R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule